// File: doc/BRIEF.md
# Serial LED Pattern Transmitter

This block drives a three-wire serial LED link (serial clock, frame-start strobe, serial data) toward a backplane controller that shows drive activity, locate and fault indications. The per-port LED encoding is built elsewhere. This block receives a packed pattern word, a port count, a leading padding count, a trailing padding count and a clock divider setting. A one-cycle start pulse begins a transfer.

A transfer runs in this order. It sends the leading padding clocks, then one serial cycle with the strobe high, then the pattern bits least significant bit first (three bits per port), then the trailing padding clocks. The padding clocks suit receivers that expect frames of a fixed length. `busy_o` is high for the whole transfer, and `done_o` pulses for one cycle when the transfer ends. The serial clock comes from the system clock through a programmable divider. The strobe and data lines change only while the serial clock is low, so the receiver samples them on the rising edge.

Top module: `led_serial_tx`

## Requirements
- R1: After reset and between transfers, `sclk_o`, `sload_o`, `sdata_o`, `busy_o` and `done_o` are all low.
- R2: Within a transfer, the serial clock starts low. Every low phase and every high phase lasts `div_i`+1 system clock cycles, where `div_i` is the value latched at the start of the transfer.
- R3: Before the strobe cycle, the block sends exactly `pre_clks_i` serial cycles with the strobe and data lines low. A value of 0 sends none.
- R4: The strobe line `sload_o` is high for exactly one serial cycle per transfer, with `sdata_o` low. That cycle comes right after the leading padding.
- R5: After the strobe cycle, `sdata_o` carries pattern bit 0 first, then bit 1, and so on, one bit per serial cycle. The number of bits is 3 × P. P is `ports_i`, except that any value above 8 counts as 8. A value of 0 sends no data bits.
- R6: After the last data bit, the block sends exactly `post_clks_i` serial cycles with the strobe and data lines low. A value of 0 sends none.
- R7: `sload_o` and `sdata_o` change only in cycles where `sclk_o` is low. A receiver that samples on the rising edge of `sclk_o` therefore sees stable values.
- R8: `busy_o` is high for exactly N × 2 × (`div_i`+1) system cycles, where N = pre + 1 + 3P + post. `done_o` is a single-cycle pulse in the cycle after `busy_o` falls, exactly once per transfer.
- R9: A start pulse while `busy_o` is high is ignored, and no transfer is queued. The pattern, port count, padding counts and divider are captured when a start is accepted, so later changes to these inputs do not affect the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted when not busy |
| pattern_i | input | 32 | Packed LED pattern, sent bit 0 first |
| ports_i | input | 4 | Port count, values above 8 count as 8 |
| pre_clks_i | input | 32 | Padding serial cycles before the strobe |
| post_clks_i | input | 32 | Padding serial cycles after the data |
| div_i | input | 16 | Serial clock phase length minus one, in system cycles |
| sclk_o | output | 1 | Serial clock |
| sload_o | output | 1 | Frame-start strobe |
| sdata_o | output | 1 | Serial data |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The bench records the strobe and data lines at every rising edge of the serial clock and compares the whole frame with one built from the inputs. It also measures the length of every clock phase. The corner cases are these: zero padding on either side, a port count of zero, a port count above the maximum, and a divider of zero. Each one catches a specific fault:
- Off-by-one padding counters add or drop a serial cycle.
- A missing clamp sends more than 24 bits.
- A design that skips the empty data phase badly leaves the strobe high or hangs.
- A wrong divider reload makes phases uneven.

The bench also changes every input and pulses start in the middle of a transfer. A design that did not latch its inputs, or that restarted, would send a corrupted frame or keep `busy_o` high too long.

// File: rtl/led_serial_pkg.sv
package led_serial_pkg;
  localparam int unsigned SIG_PER_PORT = 3;
  localparam int unsigned MAX_PORTS    = 8;
  localparam int unsigned PAT_W        = 32;
  localparam int unsigned CNT_W        = 32;
  localparam int unsigned DIV_W        = 16;
  localparam int unsigned PORT_W       = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_LOAD,
    ST_DATA,
    ST_POST
  } lsx_state_e;
endpackage

// File: rtl/lsx_clk_div.sv
module lsx_clk_div #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             en_i,
  output logic             sclk_o,
  output logic             cycle_end_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;
  logic             sclk_q;
  logic             wrap;

  assign wrap        = en_i && (cnt_q == div_q);
  assign cycle_end_o = wrap && sclk_q;
  assign sclk_o      = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      if (accept_i) div_q <= div_i;
      if (!en_i) begin
        cnt_q  <= '0;
        sclk_q <= 1'b0;
      end else if (wrap) begin
        cnt_q  <= '0;
        sclk_q <= ~sclk_q;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  // mid-phase the clock must hold its level
  assert_phase_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q != div_q) |=> $stable(sclk_q));

  assert_idle_clock_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sclk_q);
endmodule

// File: rtl/lsx_shift.sv
module lsx_shift #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] pat_i,
  output logic         bit_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= pat_i;
    else if (shift_i) sh_q <= {1'b0, sh_q[W-1:1]};
  end

  assign bit_o = sh_q[0];

  assert_no_shift_on_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && shift_i));

  assert_shift_lsb_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> (sh_q[W-2:0] == $past(sh_q[W-1:1])));
endmodule

// File: rtl/lsx_seq.sv
module lsx_seq
  import led_serial_pkg::*;
#(
  parameter int unsigned CNT_W        = 32,
  parameter int unsigned PORT_W       = 4,
  parameter int unsigned MAX_PORTS    = 8,
  parameter int unsigned SIG_PER_PORT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  pre_i,
  input  logic [CNT_W-1:0]  post_i,
  input  logic [PORT_W-1:0] ports_i,
  input  logic              cycle_end_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              shift_o,
  output logic              in_load_o,
  output logic              in_data_o
);
  localparam int unsigned BITS_MAX = MAX_PORTS * SIG_PER_PORT;
  localparam int unsigned BITS_W   = $clog2(BITS_MAX + 1);

  lsx_state_e          state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [CNT_W-1:0]    post_q;
  logic [BITS_W-1:0]   nbits_q;
  logic                done_q;
  logic [PORT_W-1:0]   ports_clamped;
  logic [BITS_W-1:0]   nbits_d;
  logic                last;

  assign ports_clamped = (ports_i > PORT_W'(MAX_PORTS)) ? PORT_W'(MAX_PORTS) : ports_i;
  assign nbits_d       = BITS_W'(ports_clamped) * BITS_W'(SIG_PER_PORT);
  assign busy_o        = (state_q != ST_IDLE);
  assign accept_o      = start_i && !busy_o;
  assign done_o        = done_q;
  assign last          = (cnt_q == CNT_W'(1));
  assign shift_o       = cycle_end_i && (state_q == ST_DATA);
  assign in_load_o     = (state_q == ST_LOAD);
  assign in_data_o     = (state_q == ST_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      post_q  <= '0;
      nbits_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        post_q  <= post_i;
        nbits_q <= nbits_d;
        cnt_q   <= pre_i;
        state_q <= (pre_i != '0) ? ST_PRE : ST_LOAD;
      end else if (cycle_end_i) begin
        unique case (state_q)
          ST_PRE: begin
            if (last) state_q <= ST_LOAD;
            else      cnt_q   <= cnt_q - 1'b1;
          end
          ST_LOAD: begin
            if (nbits_q != '0) begin
              state_q <= ST_DATA;
              cnt_q   <= CNT_W'(nbits_q);
            end else if (post_q != '0) begin
              state_q <= ST_POST;
              cnt_q   <= post_q;
            end else begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end
          end
          ST_DATA: begin
            if (!last) cnt_q <= cnt_q - 1'b1;
            else if (post_q != '0) begin
              state_q <= ST_POST;
              cnt_q   <= post_q;
            end else begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end
          end
          ST_POST: begin
            if (last) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else cnt_q <= cnt_q - 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assert_load_one_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD && cycle_end_i) |=> (state_q != ST_LOAD));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  assert_done_after_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (state_q == ST_IDLE && $past(state_q) != ST_IDLE));

  assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !cycle_end_i) |=> ($stable(post_q) && $stable(nbits_q) && $stable(cnt_q)));
endmodule

// File: rtl/led_serial_tx.sv
module led_serial_tx
  import led_serial_pkg::*;
#(
  parameter int unsigned PAT_WIDTH  = led_serial_pkg::PAT_W,
  parameter int unsigned CNT_WIDTH  = led_serial_pkg::CNT_W,
  parameter int unsigned DIV_WIDTH  = led_serial_pkg::DIV_W,
  parameter int unsigned PORT_WIDTH = led_serial_pkg::PORT_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [PAT_WIDTH-1:0]  pattern_i,
  input  logic [PORT_WIDTH-1:0] ports_i,
  input  logic [CNT_WIDTH-1:0]  pre_clks_i,
  input  logic [CNT_WIDTH-1:0]  post_clks_i,
  input  logic [DIV_WIDTH-1:0]  div_i,
  output logic                  sclk_o,
  output logic                  sload_o,
  output logic                  sdata_o,
  output logic                  busy_o,
  output logic                  done_o
);
  logic accept, cycle_end, shift, in_load, in_data, bit0;

  lsx_seq #(
    .CNT_W       (CNT_WIDTH),
    .PORT_W      (PORT_WIDTH),
    .MAX_PORTS   (MAX_PORTS),
    .SIG_PER_PORT(SIG_PER_PORT)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .pre_i      (pre_clks_i),
    .post_i     (post_clks_i),
    .ports_i    (ports_i),
    .cycle_end_i(cycle_end),
    .accept_o   (accept),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .shift_o    (shift),
    .in_load_o  (in_load),
    .in_data_o  (in_data)
  );

  lsx_clk_div #(.DIV_W(DIV_WIDTH)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .div_i      (div_i),
    .en_i       (busy_o),
    .sclk_o     (sclk_o),
    .cycle_end_o(cycle_end)
  );

  lsx_shift #(.W(PAT_WIDTH)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .shift_i(shift),
    .pat_i  (pattern_i),
    .bit_o  (bit0)
  );

  assign sload_o = in_load;
  assign sdata_o = in_data && bit0;

  assert_lines_change_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sdata_o) || !$stable(sload_o)) |-> !sclk_o);

  assert_idle_lines_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sclk_o && !sload_o && !sdata_o));

  assert_load_data_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sload_o && sdata_o));
endmodule

// File: tb/led_serial_tx_test.sv
`timescale 1ns/1ps
module led_serial_tx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] pattern = '0;
  logic [3:0]  ports = '0;
  logic [31:0] pre_c = '0, post_c = '0;
  logic [15:0] div = '0;
  logic sclk, sload, sdata, busy, done;

  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  led_serial_tx uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pattern_i(pattern),
    .ports_i(ports), .pre_clks_i(pre_c), .post_clks_i(post_c), .div_i(div),
    .sclk_o(sclk), .sload_o(sload), .sdata_o(sdata), .busy_o(busy), .done_o(done)
  );

  // monitor, sampled on the falling system clock edge
  logic       rec_ld [0:255];
  logic       rec_d  [0:255];
  int         rec_n = 0, busy_cnt = 0, done_cnt = 0, phase_err = 0, run = 0;
  int         exp_phase = 1;
  logic       prev_sclk = 1'b0, prev_busy = 1'b0;

  always @(negedge clk) begin
    if (busy) begin
      busy_cnt++;
      if (!prev_busy) begin
        run = 1;
        if (sclk) phase_err++;
      end else if (sclk == prev_sclk) run++;
      else begin
        if (run != exp_phase) phase_err++;
        run = 1;
        if (sclk && rec_n < 256) begin
          rec_ld[rec_n] = sload;
          rec_d[rec_n]  = sdata;
          rec_n++;
        end
      end
    end else if (prev_busy) begin
      if (run != exp_phase) phase_err++;
    end
    if (done) done_cnt++;
    prev_sclk = sclk;
    prev_busy = busy;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon(input int d);
    rec_n = 0; busy_cnt = 0; done_cnt = 0; phase_err = 0; exp_phase = d + 1;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // full transfer with frame, length, phase and idle checks
  task automatic run_xfer(input logic [31:0] pat, input int np, input int pre,
                          input int post, input int d, input string req);
    int p, nb, n, mism, first;
    logic eld, ed;
    p = (np > 8) ? 8 : np;
    nb = 3 * p;
    n = pre + 1 + nb + post;
    pattern = pat; ports = 4'(np); pre_c = pre; post_c = post; div = 16'(d);
    clear_mon(d);
    pulse_start();
    wait_idle();
    check(rec_n == n, req, "serial cycle count", rec_n, n);
    mism = 0; first = -1;
    for (int k = 0; k < n && k < rec_n; k++) begin
      eld = (k == pre);
      ed  = (k > pre && k <= pre + nb) ? pat[k - pre - 1] : 1'b0;
      if (rec_ld[k] != eld || rec_d[k] != ed) begin
        mism++;
        if (first < 0) first = k;
      end
    end
    check(mism == 0, req, "frame content mismatches (first index)", first, -1);
    check(phase_err == 0, "R2", "uneven clock phases", phase_err, 0);
    check(busy_cnt == n * 2 * (d + 1), "R8", "busy length", busy_cnt, n * 2 * (d + 1));
    check(done_cnt == 1, "R8", "done pulses", done_cnt, 1);
    check(!sclk && !sload && !sdata && !busy && !done, "R1", "lines after transfer",
          {sclk, sload, sdata, busy, done}, 0);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    check(!sclk && !sload && !sdata && !busy && !done, "R1", "reset state",
          {sclk, sload, sdata, busy, done}, 0);
  endtask

  task automatic t_basic();      run_xfer(32'h000A_5C3F, 2, 0, 0, 1, "R5"); endtask
  task automatic t_padding();    run_xfer(32'h00F0_F0F3, 8, 3, 2, 0, "R3/R6 R4"); endtask
  task automatic t_zero_ports(); run_xfer(32'hFFFF_FFFF, 0, 1, 1, 1, "R5 zero ports"); endtask
  task automatic t_clamp();      run_xfer(32'hFF96_69A5, 12, 0, 4, 0, "R5 clamp"); endtask
  task automatic t_slow();       run_xfer(32'h0000_0155, 3, 2, 0, 3, "R2/R3"); endtask
  task automatic t_pre_only();   run_xfer(32'h0000_0006, 1, 5, 0, 2, "R3"); endtask
  task automatic t_post_only();  run_xfer(32'h0000_0005, 1, 0, 6, 0, "R6"); endtask

  // R9: start while busy ignored, inputs latched at accept
  task automatic t_busy_start();
    int n, mism;
    pattern = 32'h0000_0FC3; ports = 4'd4; pre_c = 1; post_c = 1; div = 16'd1;
    n = 1 + 1 + 12 + 1;
    clear_mon(1);
    pulse_start();
    repeat (9) @(negedge clk);
    pattern = 32'hFFFF_FFFF; ports = 4'd1; pre_c = 7; post_c = 9; div = 16'd5;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (20) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_idle();
    check(rec_n == n, "R9", "cycles after busy start", rec_n, n);
    mism = 0;
    for (int k = 0; k < n && k < rec_n; k++)
      if (rec_d[k] != ((k >= 2 && k <= 13) ? (12'hFC3 >> (k - 2)) & 1 : 0)) mism++;
    check(mism == 0, "R9", "data mismatches after busy start", mism, 0);
    check(busy_cnt == n * 4, "R9", "busy length after busy start", busy_cnt, n * 4);
    check(done_cnt == 1 && !busy, "R9", "no queued transfer", done_cnt, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_padding();
    t_zero_ports();
    t_clamp();
    t_slow();
    t_pre_only();
    t_post_only();
    t_busy_start();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule